// File: doc/BRIEF.md
# Multi-mode 8-bit timer/event counter

This block is an 8-bit up-counter. It reloads from a preload register when it wraps, and a single control register picks its clock source. The counter can advance on edges of an external input pin (event counting) or on ticks of an internal prescaler that divides the system clock by 2 to 256 (timing). In a third mode it measures once how long the pin holds a level. In that mode, an edge of the chosen polarity starts the measurement. Prescaler ticks are counted until the pin returns to its earlier level. The block then clears its own run bit and holds the result until software sets the bit again.

Software writes the control and preload registers, and reads them and the live count, through a small register port. An overflow in any mode reloads the counter, sets a request flag and emits a one-cycle wake pulse. The request reaches the interrupt output only while the enable input is high. Software clears the flag with a dedicated strobe. The external pin passes through a two-flop synchronizer before edge detection.

Top module: `tmr_evt_ctr`

## Requirements
- R1: The counter advances by exactly one per qualifying event. When it advances from FFh, it loads the preload value instead and sets the request flag on the same clock edge.
- R2: With mode field (bits 7:6) = 10 and run bit (bit 4) set, the counter advances once every 2^(p+1) clocks, where p is the prescaler code in bits 2:0 (0..7). The prescaler restarts from zero whenever the run bit goes from 0 to 1, so the first advance comes exactly 2^(p+1) clocks after the write.
- R3: With mode field = 01 and the run bit set, each rising pin edge advances the counter once when edge bit 3 is 0, and each falling edge does so when it is 1. The other edge has no effect.
- R4: With mode field = 11 and the run bit set, a pulse of W clocks is measured. Edge bit 3 = 1 selects a high pulse and 0 selects a low pulse. The measurement adds floor((W-1)/2^(p+1)) to the counter.
- R5: When a measurement ends, hardware clears the run bit and the count is held. Further pin pulses change nothing until software sets the run bit again. No other mode clears the run bit by hardware.
- R6: Register addresses: 0 = control, 1 = preload, 2 = count (read only). Control bit 5 always reads 0.
- R7: With mode field = 00 the counter never changes, whatever the run bit and the pin do.
- R8: A preload write while the run bit is 0 also loads the counter. While the run bit is 1 it changes only the value used at the next reload.
- R9: irq_o is the request flag gated by int_en_i. flag_clr_i clears the flag. An overflow in the same cycle as a clear leaves the flag set.
- R10: wake_o is high for exactly the one cycle after each overflow.
- R11: After reset all registers, the count, the flag, irq_o and wake_o are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Write address |
| wr_data_i | input | 8 | Write data |
| rd_addr_i | input | 2 | Read address |
| rd_data_o | output | 8 | Read data, combinational |
| pin_i | input | 1 | External input pin, asynchronous |
| int_en_i | input | 1 | Interrupt enable |
| flag_clr_i | input | 1 | Software clear of the request flag |
| flag_o | output | 1 | Overflow request flag |
| irq_o | output | 1 | Gated interrupt request |
| wake_o | output | 1 | One-cycle overflow pulse |

## Verification
Two functions can land on the same edge: an overflow that sets the request flag, and a software clear of that flag. The bench starts the timer at FFh with the fastest prescaler and raises flag_clr_i in the exact cycle whose closing edge wraps the counter. It then expects the flag set, the wake pulse present and the counter reloaded. A second collision is a preload write on the very edge where a running counter advances. The counter must take the increment, not the written value, and the new value must appear only at the following reload.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  typedef enum logic [1:0] {
    MODE_IDLE  = 2'b00,
    MODE_EVENT = 2'b01,
    MODE_TIMER = 2'b10,
    MODE_PULSE = 2'b11
  } tmr_mode_e;

  typedef struct packed {
    tmr_mode_e  mode;
    logic       rsvd;
    logic       run;
    logic       edge_sel;
    logic [2:0] psc;
  } tmr_ctrl_t;

  localparam logic [1:0] ADDR_CTRL  = 2'd0;
  localparam logic [1:0] ADDR_LOAD  = 2'd1;
  localparam logic [1:0] ADDR_COUNT = 2'd2;
endpackage

// File: rtl/tmr_pin_sync.sv
module tmr_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  output logic rise_o,
  output logic fall_o
);
  // STAGES sync flops plus one history flop for edge detection
  logic [STAGES:0] sh_q;
  logic            lvl, prev;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= {sh_q[STAGES-1:0], pin_i};
  end

  assign lvl    = sh_q[STAGES-1];
  assign prev   = sh_q[STAGES];
  assign rise_o = lvl & ~prev;
  assign fall_o = ~lvl & prev;
endmodule

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
  parameter int PSC_W = 8
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       clr_i,
  input  logic [2:0] sel_i,
  output logic       tick_o
);
  logic [PSC_W-1:0] cnt_q, mask;

  always_comb begin
    for (int i = 0; i < PSC_W; i++) mask[i] = (i <= int'(sel_i));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (clr_i) cnt_q <= '0;
    else            cnt_q <= cnt_q + 1'b1;
  end

  assign tick_o = ((cnt_q & mask) == mask);
endmodule

// File: rtl/tmr_count_core.sv
module tmr_count_core
  import tmr_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  tmr_mode_e         mode_i,
  input  logic              run_i,
  input  logic              edge_sel_i,
  input  logic              rise_i,
  input  logic              fall_i,
  input  logic              tick_i,
  input  logic              load_wr_i,
  input  logic [DATA_W-1:0] load_data_i,
  output logic [DATA_W-1:0] cnt_o,
  output logic [DATA_W-1:0] preload_o,
  output logic              ovf_o,
  output logic              pw_start_o,
  output logic              pw_done_o
);
  logic [DATA_W-1:0] cnt_q, preload_q;
  logic              meas_q;
  logic              start_edge, end_edge, evt_edge, pw_mode, inc;

  assign start_edge = edge_sel_i ? rise_i : fall_i;
  assign end_edge   = edge_sel_i ? fall_i : rise_i;
  assign evt_edge   = edge_sel_i ? fall_i : rise_i;
  assign pw_mode    = run_i && (mode_i == MODE_PULSE);
  assign pw_start_o = pw_mode && !meas_q && start_edge;
  assign pw_done_o  = pw_mode && meas_q && end_edge;

  always_comb begin
    unique case (mode_i)
      MODE_EVENT: inc = run_i & evt_edge;
      MODE_TIMER: inc = run_i & tick_i;
      MODE_PULSE: inc = pw_mode & meas_q & tick_i & ~end_edge;
      default:    inc = 1'b0;
    endcase
  end

  assign ovf_o = inc && (cnt_q == '1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         meas_q <= 1'b0;
    else if (!pw_mode)   meas_q <= 1'b0;
    else if (pw_start_o) meas_q <= 1'b1;
    else if (pw_done_o)  meas_q <= 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        preload_q <= '0;
    else if (load_wr_i) preload_q <= load_data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 cnt_q <= '0;
    else if (load_wr_i && !run_i) cnt_q <= load_data_i;
    else if (ovf_o)              cnt_q <= preload_q;
    else if (inc)                cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o     = cnt_q;
  assign preload_o = preload_q;
endmodule

// File: rtl/tmr_evt_ctr.sv
module tmr_evt_ctr
  import tmr_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2,
  parameter int PSC_W       = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [1:0]        wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [1:0]        rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o,
  input  logic              pin_i,
  input  logic              int_en_i,
  input  logic              flag_clr_i,
  output logic              flag_o,
  output logic              irq_o,
  output logic              wake_o
);
  localparam int CTRL_W = $bits(tmr_ctrl_t);

  tmr_ctrl_t         ctrl_q, ctrl_wr;
  logic              ctrl_we, load_we;
  logic              rise, fall, tick, ovf, pw_start, pw_done;
  logic              flag_q, wake_q;
  logic [DATA_W-1:0] cnt, preload;

  assign ctrl_we = wr_en_i && (wr_addr_i == ADDR_CTRL);
  assign load_we = wr_en_i && (wr_addr_i == ADDR_LOAD);

  always_comb begin
    ctrl_wr      = tmr_ctrl_t'(wr_data_i[CTRL_W-1:0]);
    ctrl_wr.rsvd = 1'b0;
  end

  // software write wins over the hardware clear at measurement end
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        ctrl_q     <= '0;
    else if (ctrl_we)   ctrl_q     <= ctrl_wr;
    else if (pw_done)   ctrl_q.run <= 1'b0;
  end

  tmr_pin_sync #(.STAGES(SYNC_STAGES)) i_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .pin_i  (pin_i),
    .rise_o (rise),
    .fall_o (fall)
  );

  tmr_prescaler #(.PSC_W(PSC_W)) i_psc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (!ctrl_q.run || pw_start),
    .sel_i  (ctrl_q.psc),
    .tick_o (tick)
  );

  tmr_count_core #(.DATA_W(DATA_W)) i_core (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .mode_i      (ctrl_q.mode),
    .run_i       (ctrl_q.run),
    .edge_sel_i  (ctrl_q.edge_sel),
    .rise_i      (rise),
    .fall_i      (fall),
    .tick_i      (tick),
    .load_wr_i   (load_we),
    .load_data_i (wr_data_i),
    .cnt_o       (cnt),
    .preload_o   (preload),
    .ovf_o       (ovf),
    .pw_start_o  (pw_start),
    .pw_done_o   (pw_done)
  );

  // overflow set dominates a same-cycle clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_q <= 1'b0;
      wake_q <= 1'b0;
    end else begin
      wake_q <= ovf;
      if (ovf)             flag_q <= 1'b1;
      else if (flag_clr_i) flag_q <= 1'b0;
    end
  end

  always_comb begin
    unique case (rd_addr_i)
      ADDR_CTRL:  rd_data_o = DATA_W'(ctrl_q);
      ADDR_LOAD:  rd_data_o = preload;
      ADDR_COUNT: rd_data_o = cnt;
      default:    rd_data_o = '0;
    endcase
  end

  assign flag_o = flag_q;
  assign irq_o  = flag_q & int_en_i;
  assign wake_o = wake_q;
endmodule

// File: rtl/tmr_evt_ctr_chk.sv
module tmr_evt_ctr_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_en_i,
  input logic [1:0]        wr_addr_i,
  input logic [1:0]        rd_addr_i,
  input logic [DATA_W-1:0] rd_data_o,
  input logic              int_en_i,
  input logic              flag_o,
  input logic              irq_o,
  input logic              wake_o,
  input logic [DATA_W-1:0] cnt,
  input logic [DATA_W-1:0] preload,
  input logic [7:0]        ctrl_bits
);
  AST_RSVD_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_addr_i == 2'd0) |-> !rd_data_o[5]); // R6

  AST_IRQ_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !int_en_i |-> !irq_o); // R9

  AST_WAKE_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_o |-> flag_o); // R10

  AST_RELOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_o |-> (cnt == $past(preload))); // R1

  AST_STEP_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((cnt != $past(cnt)) && !wake_o && !$past(wr_en_i && wr_addr_i == 2'd1))
      |-> (cnt == DATA_W'($past(cnt) + 1'b1))); // R1

  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (($past(ctrl_bits[7:6]) == 2'b00) && !$past(wr_en_i)) |-> $stable(cnt)); // R7

  AST_RUN_HW_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(ctrl_bits[4]) && !$past(wr_en_i && wr_addr_i == 2'd0))
      |-> ($past(ctrl_bits[7:6]) == 2'b11)); // R5
endmodule

bind tmr_evt_ctr tmr_evt_ctr_chk #(.DATA_W(DATA_W)) i_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .wr_en_i   (wr_en_i),
  .wr_addr_i (wr_addr_i),
  .rd_addr_i (rd_addr_i),
  .rd_data_o (rd_data_o),
  .int_en_i  (int_en_i),
  .flag_o    (flag_o),
  .irq_o     (irq_o),
  .wake_o    (wake_o),
  .cnt       (cnt),
  .preload   (preload),
  .ctrl_bits (ctrl_q)
);

// File: tb/test_tmr_evt_ctr.sv
module test_tmr_evt_ctr;
  localparam int CLK_PERIOD = 10;
  localparam logic [1:0] A_CTRL = 2'd0, A_LOAD = 2'd1, A_CNT = 2'd2;

  logic       clk_i = 1'b0, rst_ni = 1'b0;
  logic       wr_en_i = 1'b0;
  logic [1:0] wr_addr_i = '0, rd_addr_i = '0;
  logic [7:0] wr_data_i = '0, rd_data_o;
  logic       pin_i = 1'b0, int_en_i = 1'b0, flag_clr_i = 1'b0;
  logic       flag_o, irq_o, wake_o;
  int         n_chk = 0, n_bad = 0;
  logic       done = 1'b0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  tmr_evt_ctr i_tmr_evt_ctr (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i),
    .wr_data_i(wr_data_i), .rd_addr_i(rd_addr_i), .rd_data_o(rd_data_o),
    .pin_i(pin_i), .int_en_i(int_en_i), .flag_clr_i(flag_clr_i),
    .flag_o(flag_o), .irq_o(irq_o), .wake_o(wake_o)
  );

  task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d);
    @(negedge clk_i);
    wr_en_i = 1'b1; wr_addr_i = a; wr_data_i = d;
    @(posedge clk_i); #1;
    wr_en_i = 1'b0;
  endtask

  task automatic rd(logic [1:0] a, output logic [7:0] d);
    rd_addr_i = a; #1; d = rd_data_o;
  endtask

  task automatic pin_set(logic v, int cyc);
    @(negedge clk_i); pin_i = v;
    repeat (cyc) @(posedge clk_i);
    #1;
  endtask

  task automatic clr_flag();
    @(negedge clk_i); flag_clr_i = 1'b1;
    @(posedge clk_i); #1; flag_clr_i = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] v, base;
    repeat (3) @(posedge clk_i);
    @(negedge clk_i); rst_ni = 1'b1;
    @(posedge clk_i); #1;

    // R11 reset state
    rd(A_CTRL, v); check("R11 ctrl", v, 8'h00);
    rd(A_LOAD, v); check("R11 preload", v, 8'h00);
    rd(A_CNT, v);  check("R11 count", v, 8'h00);
    check("R11 flag/irq/wake", {5'd0, flag_o, irq_o, wake_o}, 8'h00);

    // R6 reserved bit
    wr(A_CTRL, 8'hFF); rd(A_CTRL, v); check("R6 ctrl readback", v, 8'hDF);
    wr(A_CTRL, 8'h00);

    // R8 stopped preload loads counter
    wr(A_LOAD, 8'h5A); rd(A_CNT, v); check("R8 stopped load", v, 8'h5A);

    // R2 timer sweep over all prescaler codes
    for (int p = 0; p < 8; p++) begin
      int d;
      d = 2 << p;
      wr(A_CTRL, 8'h80 | 8'(p));
      wr(A_LOAD, 8'h00);
      wr(A_CTRL, 8'h90 | 8'(p));
      repeat (3*d - 1) @(posedge clk_i); #1;
      rd(A_CNT, v); check($sformatf("R2 psc%0d before", p), v, 8'd2);
      @(posedge clk_i); #1;
      rd(A_CNT, v); check($sformatf("R2 psc%0d at 3 periods", p), v, 8'd3);
    end
    wr(A_CTRL, 8'h00);

    // R1 / R10 / R8 overflow and reload
    wr(A_LOAD, 8'hFD);
    wr(A_CTRL, 8'h90);
    repeat (6) @(posedge clk_i); #1;
    rd(A_CNT, v); check("R1 reload value", v, 8'hFD);
    check("R1 flag set", {7'd0, flag_o}, 8'd1);
    check("R10 wake high", {7'd0, wake_o}, 8'd1);
    check("R9 irq masked", {7'd0, irq_o}, 8'd0);
    @(posedge clk_i); #1;
    check("R10 wake one cycle", {7'd0, wake_o}, 8'd0);
    wr(A_LOAD, 8'h10);
    rd(A_CNT, v); check("R8 running write not loaded", v, 8'hFE);
    repeat (4) @(posedge clk_i); #1;
    rd(A_CNT, v); check("R8 new preload used", v, 8'h10);
    int_en_i = 1'b1; #1;
    check("R9 irq enabled", {7'd0, irq_o}, 8'd1);
    wr(A_CTRL, 8'h00);
    clr_flag();
    check("R9 flag cleared", {6'd0, flag_o, irq_o}, 8'd0);

    // R9 overflow and clear in the same cycle
    wr(A_LOAD, 8'hFF);
    wr(A_CTRL, 8'h90);
    @(negedge clk_i); @(negedge clk_i); flag_clr_i = 1'b1;
    @(posedge clk_i); #1; flag_clr_i = 1'b0;
    check("R9 set beats clear", {6'd0, flag_o, wake_o}, 8'd3);
    rd(A_CNT, v); check("R1 reload FF", v, 8'hFF);
    wr(A_CTRL, 8'h00);
    clr_flag();
    int_en_i = 1'b0;

    // R3 event count, rising then falling
    pin_set(1'b0, 6);
    wr(A_LOAD, 8'h00);
    wr(A_CTRL, 8'h50);
    for (int i = 0; i < 4; i++) begin
      pin_set(1'b1, 6); rd(A_CNT, v); check("R3 rising counted", v, 8'(i + 1));
      pin_set(1'b0, 6); rd(A_CNT, v); check("R3 falling ignored", v, 8'(i + 1));
    end
    wr(A_CTRL, 8'h00);
    wr(A_LOAD, 8'h00);
    wr(A_CTRL, 8'h58);
    for (int i = 0; i < 4; i++) begin
      pin_set(1'b1, 6); rd(A_CNT, v); check("R3 rising ignored", v, 8'(i));
      pin_set(1'b0, 6); rd(A_CNT, v); check("R3 falling counted", v, 8'(i + 1));
    end
    wr(A_CTRL, 8'h00);

    // R7 idle mode
    wr(A_LOAD, 8'h33);
    wr(A_CTRL, 8'h10);
    for (int i = 0; i < 5; i++) begin
      pin_set(1'b1, 40); pin_set(1'b0, 40);
    end
    rd(A_CNT, v); check("R7 idle holds", v, 8'h33);
    wr(A_CTRL, 8'h00);

    // R4 / R5 pulse width sweep
    for (int te = 1; te >= 0; te--) begin
      for (int p = 0; p < 3; p++) begin
        for (int w = 1; w <= 10; w++) begin
          int d;
          d = 2 << p;
          wr(A_CTRL, 8'h00);
          pin_set(te == 0, 4);
          wr(A_LOAD, 8'h00);
          wr(A_CTRL, 8'hD0 | 8'(te << 3) | 8'(p));
          repeat (2) @(posedge clk_i);
          @(negedge clk_i); pin_i = (te == 1);
          repeat (w) @(negedge clk_i);
          pin_i = (te == 0);
          repeat (6) @(posedge clk_i); #1;
          rd(A_CNT, v);
          check($sformatf("R4 te%0d psc%0d w%0d", te, p, w), v, 8'((w - 1) / d));
          rd(A_CTRL, v);
          check("R5 run cleared", v & 8'h10, 8'h00);
          if (w == 10) begin
            base = 8'((w - 1) / d);
            pin_set(te == 1, 9); pin_set(te == 0, 6);
            rd(A_CNT, v); check("R5 second pulse ignored", v, base);
          end
        end
      end
    end
    wr(A_CTRL, 8'h00);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule